// File: doc/BRIEF.md
# CAN Controller Mode Control Register

This block holds the mode-control register of a CAN protocol controller. Host software uses it to enter and leave initialization, to unlock writes to the controller's protected configuration registers, to enter a restricted operating mode, and to request that the controller's clocks be stopped. A small synchronous register port accepts writes with a per-bit write mask and returns a readback word. Two status inputs from the protocol engine say whether transmit requests are still pending and whether the bus is idle.

The initialization flag lives in the host domain. It is carried into the protocol clock domain through a two-flop synchronizer and carried back through a second one. The readback shows the returned copy, so software sees a new value only once the protocol side has taken it. While a change is still in flight, further writes to the flag are dropped. A clock-stop request is served in a fixed order. First the block waits until transfers have drained and the bus is idle. Then it raises initialization, and only once the returned copy shows it set does it raise the stop acknowledge.

Top module: `can_mode_ctrl`

## Requirements
- R1: After reset, rd_data reads 0 and init_proto, cfg_wr_en, restricted_mode and clk_stop_ack are all 0.
- R2: A write changes only those register bits whose wr_mask bit is 1. Bit 4 (stop acknowledge) and bits 5 and up cannot be written. Bit layout: bit 0 initialization, bit 1 configuration unlock, bit 2 restricted mode, bit 3 clock-stop request, bit 4 clock-stop acknowledge.
- R3: With both clocks equal, a write that sets bit 0 on clock edge k drives init_proto high after edge k+2 and shows bit 0 as 1 in rd_data after edge k+4, not earlier.
- R4: A write to bit 0 is ignored while a previous change of bit 0 has not yet returned to the readback.
- R5: A write to bit 1 takes effect only when readback bit 0 is 1 at the time of the write; otherwise it is ignored.
- R6: Clearing bit 0 clears bit 1.
- R7: cfg_wr_en is 1 exactly when readback bits 0 and 1 are both 1.
- R8: Bit 2 can be set only while bits 0 and 1 both read 1. Writing it to 0 clears it in any state, and clearing bit 0 does not clear it.
- R9: While bit 3 is set and xfer_pending is 1 or bus_idle is 0, the block sets neither bit 0 nor the stop acknowledge.
- R10: Once the bus has drained after a stop request, bit 0 reads 1 first. clk_stop_ack (bit 4) rises only on a later cycle, and only while bit 0 reads 1.
- R11: One cycle after bit 3 is cleared, clk_stop_ack is 0.
- R12: restricted_mode always equals readback bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Host-side clock |
| rst_n | input | 1 | Host-side active-low reset |
| proto_clk | input | 1 | Protocol-engine clock |
| proto_rst_n | input | 1 | Protocol-domain active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_mask | input | REG_W | Per-bit write enable |
| wr_data | input | REG_W | Write data |
| rd_data | output | REG_W | Register readback |
| xfer_pending | input | 1 | Protocol engine still has transfer requests |
| bus_idle | input | 1 | CAN bus is idle |
| init_proto | output | 1 | Initialization flag in the protocol domain |
| cfg_wr_en | output | 1 | Write gate for protected configuration registers |
| restricted_mode | output | 1 | Restricted operating mode active |
| clk_stop_ack | output | 1 | Controller clocks may be stopped |

## Verification
The hardest state to reach is a second write to the initialization bit landing while the first change is still crossing the two synchronizers. A directed sequence writes the bit on back-to-back cycles to exercise it. The stop handshake also needs a specific input history: the request must be held while transfers are pending, then while the bus is busy, and only then released. The bench shapes xfer_pending and bus_idle in those phases and records the cycle in which bit 0 and the acknowledge first appear. Random masked writes are spaced past the round-trip latency so that a bench model can follow the unlock and restricted-mode rules.

// File: rtl/can_mode_pkg.sv
package can_mode_pkg;

  // register bit positions (software visible layout)
  localparam int F_INIT    = 0;
  localparam int F_CFG     = 1;
  localparam int F_RSTR    = 2;
  localparam int F_STOPREQ = 3;
  localparam int F_STOPACK = 4;
  localparam int NUM_FIELDS = 5;

  typedef enum logic [1:0] {
    STP_IDLE  = 2'd0,
    STP_DRAIN = 2'd1,
    STP_INIT  = 2'd2,
    STP_ACK   = 2'd3
  } stop_state_e;

  // bus is quiet enough to stop: nothing queued and no frame on the wire
  function automatic logic drain_ok(input logic pending, input logic idle);
    return !pending && idle;
  endfunction

  // protected configuration access is open
  function automatic logic cfg_open(input logic init_seen, input logic unlock);
    return init_seen && unlock;
  endfunction

  // restricted mode may be entered
  function automatic logic rstr_allowed(input logic init_seen, input logic unlock);
    return init_seen && unlock;
  endfunction

endpackage

// File: rtl/can_mode_sync.sv
module can_mode_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  localparam int LAST = STAGES - 1;

  logic [STAGES-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain <= '0;
    end else begin
      chain[0] <= d;
      for (int i = 1; i < STAGES; i++) begin
        chain[i] <= chain[i-1];
      end
    end
  end

  assign q = chain[LAST];
endmodule

// File: rtl/can_mode_fields.sv
module can_mode_fields
  import can_mode_pkg::*;
#(
  parameter int REG_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_mask,
  input  logic [REG_W-1:0] wr_data,
  input  logic             init_ack,
  input  logic             set_init,
  output logic             init_req,
  output logic             cce_q,
  output logic             asm_q,
  output logic             stop_req,
  output logic             init_busy
);
  logic [REG_W-1:0] strobe;
  logic             init_wr_ok;

  assign strobe     = wr_mask & {REG_W{wr_en}};
  assign init_busy  = init_req != init_ack;
  assign init_wr_ok = !init_busy;

  // initialization request: frozen while a change is crossing domains
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      init_req <= 1'b0;
    end else if (init_wr_ok) begin
      if (set_init) begin
        init_req <= 1'b1;
      end else if (strobe[F_INIT]) begin
        init_req <= wr_data[F_INIT];
      end
    end
  end

  // configuration unlock: needs the returned init, dropped when init is cleared
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cce_q <= 1'b0;
    end else if (!init_req) begin
      cce_q <= 1'b0;
    end else if (strobe[F_CFG] && init_ack) begin
      cce_q <= wr_data[F_CFG];
    end
  end

  // restricted mode: set under unlock, clear at will
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      asm_q <= 1'b0;
    end else if (strobe[F_RSTR]) begin
      if (!wr_data[F_RSTR]) begin
        asm_q <= 1'b0;
      end else if (rstr_allowed(init_ack, cce_q)) begin
        asm_q <= 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stop_req <= 1'b0;
    end else if (strobe[F_STOPREQ]) begin
      stop_req <= wr_data[F_STOPREQ];
    end
  end
endmodule

// File: rtl/can_mode_stopseq.sv
module can_mode_stopseq
  import can_mode_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic stop_req,
  input  logic drained,
  input  logic init_req,
  input  logic init_ack,
  input  logic init_busy,
  output logic set_init,
  output logic csa
);
  stop_state_e state_q, state_d;

  always_comb begin
    state_d  = state_q;
    set_init = 1'b0;
    if (!stop_req) begin
      state_d = STP_IDLE;
    end else begin
      unique case (state_q)
        STP_IDLE:  state_d = STP_DRAIN;
        STP_DRAIN: begin
          if (drained && !init_busy) begin
            set_init = 1'b1;
            state_d  = STP_INIT;
          end
        end
        STP_INIT: begin
          if (!init_req) begin
            state_d = STP_DRAIN;
          end else if (init_ack && drained) begin
            state_d = STP_ACK;
          end
        end
        STP_ACK: begin
          if (!init_req) begin
            state_d = STP_DRAIN;
          end
        end
        default: state_d = STP_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= STP_IDLE;
    end else begin
      state_q <= state_d;
    end
  end

  assign csa = state_q == STP_ACK;
endmodule

// File: rtl/can_mode_ctrl.sv
module can_mode_ctrl
  import can_mode_pkg::*;
#(
  parameter int REG_W     = 8,
  parameter int SYNC_FWD  = 2,
  parameter int SYNC_BACK = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             proto_clk,
  input  logic             proto_rst_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_mask,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data,
  input  logic             xfer_pending,
  input  logic             bus_idle,
  output logic             init_proto,
  output logic             cfg_wr_en,
  output logic             restricted_mode,
  output logic             clk_stop_ack
);
  localparam int SPARE_W = REG_W - NUM_FIELDS;

  // named internal events, also used by the bound checker
  logic init_req;
  logic init_ack;
  logic init_busy;
  logic cce_q;
  logic asm_q;
  logic stop_req;
  logic set_init;
  logic csa;
  logic drained;

  assign drained = drain_ok(xfer_pending, bus_idle);

  can_mode_fields #(.REG_W(REG_W)) u_fields (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_mask   (wr_mask),
    .wr_data   (wr_data),
    .init_ack  (init_ack),
    .set_init  (set_init),
    .init_req  (init_req),
    .cce_q     (cce_q),
    .asm_q     (asm_q),
    .stop_req  (stop_req),
    .init_busy (init_busy)
  );

  // host -> protocol domain
  can_mode_sync #(.STAGES(SYNC_FWD)) u_fwd (
    .clk   (proto_clk),
    .rst_n (proto_rst_n),
    .d     (init_req),
    .q     (init_proto)
  );

  // protocol -> host domain
  can_mode_sync #(.STAGES(SYNC_BACK)) u_back (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (init_proto),
    .q     (init_ack)
  );

  can_mode_stopseq u_stop (
    .clk       (clk),
    .rst_n     (rst_n),
    .stop_req  (stop_req),
    .drained   (drained),
    .init_req  (init_req),
    .init_ack  (init_ack),
    .init_busy (init_busy),
    .set_init  (set_init),
    .csa       (csa)
  );

  always_comb begin
    rd_data            = '0;
    rd_data[F_INIT]    = init_ack;
    rd_data[F_CFG]     = cce_q;
    rd_data[F_RSTR]    = asm_q;
    rd_data[F_STOPREQ] = stop_req;
    rd_data[F_STOPACK] = csa;
  end

  assign cfg_wr_en       = cfg_open(init_ack, cce_q);
  assign restricted_mode = asm_q;
  assign clk_stop_ack    = csa;

  generate
    if (SPARE_W < 0) begin : g_bad_width
      initial $error("REG_W too small for the mode fields");
    end
  endgenerate
endmodule

// File: rtl/can_mode_ctrl_chk.sv
module can_mode_ctrl_chk (
  input logic clk,
  input logic rst_n,
  input logic init_req,
  input logic init_ack,
  input logic cce_q,
  input logic asm_q,
  input logic stop_req,
  input logic csa,
  input logic drained
);
  // returned init only moves to the value the host side is holding
  assert_init_return_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(init_ack) |-> (init_ack == init_req));

  assert_cfg_needs_init_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cce_q) |-> $past(init_ack));

  assert_cfg_drops_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !init_req |=> !cce_q);

  assert_rstr_gate_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(asm_q) |-> $past(cce_q && init_ack));

  assert_ack_after_drain_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(csa) |-> $past(drained));

  assert_ack_after_init_R10: assert property (@(posedge clk) disable iff (!rst_n)
    csa |-> init_ack);

  assert_ack_drops_R11: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(stop_req) |=> !csa);
endmodule

bind can_mode_ctrl can_mode_ctrl_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .init_req (init_req),
  .init_ack (init_ack),
  .cce_q    (cce_q),
  .asm_q    (asm_q),
  .stop_req (stop_req),
  .csa      (csa),
  .drained  (drained)
);

// File: tb/can_mode_ctrl_bench.sv
`timescale 1ns/1ps
module can_mode_ctrl_bench;
  localparam int REG_W = 8;

  logic             clk = 1'b0;
  logic             rst_n = 1'b0;
  logic             wr_en = 1'b0;
  logic [REG_W-1:0] wr_mask = '0;
  logic [REG_W-1:0] wr_data = '0;
  logic [REG_W-1:0] rd_data;
  logic             xfer_pending = 1'b0;
  logic             bus_idle = 1'b1;
  logic             init_proto, cfg_wr_en, restricted_mode, clk_stop_ack;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  can_mode_ctrl #(.REG_W(REG_W)) u_can_mode_ctrl (
    .clk             (clk),
    .rst_n           (rst_n),
    .proto_clk       (clk),
    .proto_rst_n     (rst_n),
    .wr_en           (wr_en),
    .wr_mask         (wr_mask),
    .wr_data         (wr_data),
    .rd_data         (rd_data),
    .xfer_pending    (xfer_pending),
    .bus_idle        (bus_idle),
    .init_proto      (init_proto),
    .cfg_wr_en       (cfg_wr_en),
    .restricted_mode (restricted_mode),
    .clk_stop_ack    (clk_stop_ack)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [REG_W-1:0] d, input logic [REG_W-1:0] m);
    @(negedge clk);
    wr_en = 1'b1; wr_data = d; wr_mask = m;
    @(negedge clk);
    wr_en = 1'b0; wr_data = '0; wr_mask = '0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // bench-side reference of the register rules
  function automatic logic [2:0] model_next(input logic [2:0] cur, input logic [REG_W-1:0] d,
                                            input logic [REG_W-1:0] m);
    logic i, c, a;
    i = cur[0]; c = cur[1]; a = cur[2];
    if (m[2]) a = d[2] ? (a | (cur[0] & cur[1])) : 1'b0;
    if (m[1] && cur[0]) c = d[1];
    if (m[0]) i = d[0];
    if (!i) c = 1'b0;
    return {a, c, i};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int t_init, t_ack, cyc;
    logic [2:0] m;
    void'($urandom(32'd1234));
    idle(3);
    // R1 reset state
    check("R1 rd_data", rd_data, 0);
    check("R1 outputs", {init_proto, cfg_wr_en, restricted_mode, clk_stop_ack}, 0);
    rst_n = 1'b1;
    idle(2);
    check("R1 after release", rd_data, 0);

    // R5 unlock ignored while init clear
    wr(8'h02, 8'h02);
    idle(2);
    check("R5 unlock ignored", rd_data[1], 0);
    check("R7 gate closed", cfg_wr_en, 0);

    // R3 crossing latency
    wr(8'h01, 8'h01);
    check("R3 proto k", init_proto, 0);
    idle(1);
    check("R3 proto k+1", init_proto, 0);
    idle(1);
    check("R3 proto k+2", init_proto, 1);
    check("R3 rd k+2", rd_data[0], 0);
    idle(1);
    check("R3 rd k+3", rd_data[0], 0);
    idle(1);
    check("R3 rd k+4", rd_data[0], 1);

    // R2 read-only and spare bits, masked-out bits
    wr(8'hFF, 8'hF0);
    idle(1);
    check("R2 ro bits", rd_data, 8'h01);
    wr(8'h00, 8'h06);
    idle(1);
    check("R2 masked init kept", rd_data, 8'h01);

    // R8 restricted refused without unlock
    wr(8'h04, 8'h04);
    idle(1);
    check("R8 refused", rd_data[2], 0);
    check("R12 mirror", restricted_mode, 0);

    // R5 / R7 unlock with init
    wr(8'h02, 8'h02);
    idle(1);
    check("R5 unlock", rd_data[1], 1);
    check("R7 gate open", cfg_wr_en, 1);
    wr(8'h04, 8'h04);
    idle(1);
    check("R8 set", rd_data[2], 1);
    check("R12 mirror set", restricted_mode, 1);

    // R6 clearing init drops unlock, keeps restricted
    wr(8'h00, 8'h01);
    idle(1);
    check("R6 unlock dropped", rd_data[1], 0);
    check("R7 gate after clear", cfg_wr_en, 0);
    idle(5);
    check("R6 init cleared", rd_data[0], 0);
    check("R8 kept", rd_data[2], 1);
    wr(8'h00, 8'h04);
    idle(1);
    check("R8 cleared", rd_data[2], 0);

    // R4 write during crossing ignored
    wr(8'h01, 8'h01);
    wr(8'h00, 8'h01);
    idle(8);
    check("R4 in-flight write dropped", rd_data[0], 1);
    wr(8'h00, 8'h01);
    idle(6);
    check("R4 settled write", rd_data[0], 0);

    // R9 / R10 / R11 clock-stop handshake
    xfer_pending = 1'b1;
    wr(8'h08, 8'h08);
    idle(20);
    check("R9 pending no init", rd_data[0], 0);
    check("R9 pending no ack", clk_stop_ack, 0);
    xfer_pending = 1'b0; bus_idle = 1'b0;
    idle(10);
    check("R9 busy no init", rd_data[0], 0);
    check("R9 busy no ack", clk_stop_ack, 0);
    bus_idle = 1'b1;
    t_init = -1; t_ack = -1;
    for (int c = 0; c < 30; c++) begin
      @(negedge clk);
      if (clk_stop_ack && t_ack < 0) begin
        t_ack = c;
        check("R10 init before ack", rd_data[0], 1);
      end
      if (rd_data[0] && t_init < 0) t_init = c;
    end
    check("R10 init seen", t_init >= 0, 1);
    check("R10 ack seen", t_ack >= 0, 1);
    check("R10 order", t_ack > t_init, 1);
    check("R10 ack bit", rd_data[4], 1);
    wr(8'h00, 8'h08);
    idle(1);
    check("R11 ack dropped", clk_stop_ack, 0);
    check("R11 ack bit", rd_data[4], 0);
    wr(8'h00, 8'h01);
    idle(6);
    wr(8'h00, 8'h07);
    idle(6);
    check("R1 clean before random", rd_data, 0);

    // random masked writes, spaced beyond the round trip
    m = 3'b000;
    for (int n = 0; n < 300; n++) begin
      logic [REG_W-1:0] d, k;
      d = REG_W'($urandom);
      k = REG_W'($urandom) & 8'hF7;
      wr(d, k);
      idle(6);
      m = model_next(m, d, k);
      check("R5 R6 R8 random fields", rd_data[2:0], m);
      check("R7 random gate", cfg_wr_en, m[0] & m[1]);
      check("R12 random mirror", restricted_mode, m[2]);
      check("R2 random upper", rd_data[7:3], 0);
    end
    cyc = 0;

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule